// File: doc/BRIEF.md
# Laser Safety Fault Recovery Controller

This block supervises the safety shutdown of a laser transmitter. It takes digital over-limit flags that have already been compared against their limits: high bias current, high optical power and low optical power. When one of them trips while the transmitter is enabled, the block latches a safety fault. It then holds the gate-drive enable and the DAC enable low and raises a fault output.

The host clears a fault by pulsing the transmit-disable request. The request is the OR of an external pin and an internal control bit. When the request falls, recovery begins at once: both enables come back and a timer starts. The fault output stays high for a parameterised number of clock ticks so the loop can settle. While that timer runs, only the low-power flag is masked. The high-bias and high-power flags stay live, and a trip on either of them latches a new fault at once.

An ordinary shutdown through the disable request never counts as a fault.

Top module: `laser_safety_sup`

## Requirements
- R1: The effective disable request is `tx_disable_pin OR tx_disable_ctl`. With no fault latched, `gate_drive_en` and `dac_en` both equal the inverse of that request, combinationally.
- R2: While the effective disable request is high, no flag can latch a fault, so `fault_out` stays low through a normal shutdown.
- R3: While the request is low, `hi_bias_flag` or `hi_power_flag` high at a clock edge latches a fault. From the next cycle, `fault_out` is 1 and both enables are 0.
- R4: While the request is low and no recovery window is running, `lo_power_flag` high at a clock edge latches a fault in the same way.
- R5: A latched fault holds `fault_out` high and both enables low after all flags clear. Only a falling edge of the effective disable request releases it.
- R6: A falling edge of the request with a fault latched clears the latch at that edge. From the next cycle the enables follow the request again. `fault_out` stays high until REC_TICKS further cycles with `tick` high have passed, and then goes low.
- R7: `lo_power_masked` equals `lo_power_flag` except during the recovery window, including the cycle of the starting edge, when it is 0. During that window a high `lo_power_flag` latches no fault.
- R8: During the recovery window, `hi_bias_flag` or `hi_power_flag` with the request low latches a new fault, as in R3.
- R9: A falling edge of the request while the window is running restarts the window at the full REC_TICKS count.
- R10: After reset no fault is latched, no window runs, `fault_out` is 0 and the enables follow the request.
- R11: A falling edge of the request with no fault latched and no window running has no effect: `fault_out` stays 0 and no masking starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe that advances the recovery timer |
| tx_disable_pin | input | 1 | External transmit-disable request |
| tx_disable_ctl | input | 1 | Internal transmit-disable control bit |
| hi_bias_flag | input | 1 | Bias current over limit |
| hi_power_flag | input | 1 | Optical power over high limit |
| lo_power_flag | input | 1 | Optical power under low limit |
| gate_drive_en | output | 1 | Laser gate-drive enable |
| dac_en | output | 1 | Bias/modulation DAC enable |
| fault_out | output | 1 | Safety fault indication |
| lo_power_masked | output | 1 | Low-power flag after recovery masking |

## Verification
The bench targets the window edges. A timer that counted clocks instead of ticks, or that was off by one, would drop `fault_out` on the wrong cycle. A mask that missed the starting edge cycle would let a low-power reading latch a fresh fault the instant recovery begins. It also checks that a shutdown with every flag high leaves `fault_out` low, that a second release mid-window restarts the full count rather than leaving it running, and that a release with no fault pending opens no window. A design that treated the high flags like the low-power flag would let a high-power trip in the window pass unlatched.

// File: rtl/laser_sup_pkg.sv
package laser_sup_pkg;

  // effective transmit-disable request
  function automatic logic f_eff_disable(input logic pin, input logic ctl);
    return pin | ctl;
  endfunction

  // a trip is only possible while the transmitter runs; low power honours the mask
  function automatic logic f_trip(input logic dis, input logic hb, input logic hp,
                                  input logic lp, input logic mask);
    return !dis && (hb || hp || (lp && !mask));
  endfunction

  // recovery counter next value
  function automatic int unsigned f_cnt_next(input int unsigned cur, input logic load,
                                             input logic tick, input int unsigned full);
    if (load)
      return full;
    else if (tick && cur != 0)
      return cur - 1;
    else
      return cur;
  endfunction

endpackage

// File: rtl/lsr_disable_edge.sv
module lsr_disable_edge
  import laser_sup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic ctl,
  output logic dis,
  output logic dis_fall
);
  logic dis_q;

  assign dis = f_eff_disable(pin, ctl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dis_q <= 1'b0;
    else
      dis_q <= dis;
  end

  assign dis_fall = dis_q & ~dis;

  p_fall_is_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> (dis_fall == !dis));
  p_no_fall_when_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dis |-> !dis_fall);
endmodule

// File: rtl/lsr_rec_timer.sv
module lsr_rec_timer
  import laser_sup_pkg::*;
#(
  parameter int unsigned REC_TICKS = 8,
  localparam int unsigned CNT_W = $clog2(REC_TICKS + 1)
)(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic active
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(f_cnt_next(int'(cnt_q), start, tick, REC_TICKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  p_load_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == CNT_W'(REC_TICKS)));
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && tick && active) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !tick) |=> $stable(cnt_q));
  p_idle_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !active) |=> !active);
endmodule

// File: rtl/lsr_fault_core.sv
module lsr_fault_core
  import laser_sup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dis,
  input  logic dis_fall,
  input  logic win_active,
  input  logic hb,
  input  logic hp,
  input  logic lp,
  output logic fault_q,
  output logic rec_start,
  output logic lp_mask,
  output logic trip
);
  assign rec_start = dis_fall & (fault_q | win_active);
  assign lp_mask   = win_active | rec_start;
  assign trip      = f_trip(dis, hb, hp, lp, lp_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fault_q <= 1'b0;
    else if (trip)
      fault_q <= 1'b1;
    else if (rec_start)
      fault_q <= 1'b0;
  end

  p_trip_latches_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> fault_q);
  p_fault_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !dis_fall) |=> fault_q);
  p_shutdown_no_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dis |-> !trip);
  p_hi_flags_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis && (hb || hp)) |=> fault_q);
  p_idle_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_fall && !fault_q && !win_active && !trip) |=> !fault_q);
endmodule

// File: rtl/laser_safety_sup.sv
module laser_safety_sup
  import laser_sup_pkg::*;
#(
  parameter int unsigned REC_TICKS = 8
)(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_disable_pin,
  input  logic tx_disable_ctl,
  input  logic hi_bias_flag,
  input  logic hi_power_flag,
  input  logic lo_power_flag,
  output logic gate_drive_en,
  output logic dac_en,
  output logic fault_out,
  output logic lo_power_masked
);
  logic dis;
  logic dis_fall;
  logic win_active;
  logic fault_q;
  logic rec_start;
  logic lp_mask;
  logic trip;

  lsr_disable_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (tx_disable_pin),
    .ctl      (tx_disable_ctl),
    .dis      (dis),
    .dis_fall (dis_fall)
  );

  lsr_fault_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .dis        (dis),
    .dis_fall   (dis_fall),
    .win_active (win_active),
    .hb         (hi_bias_flag),
    .hp         (hi_power_flag),
    .lp         (lo_power_flag),
    .fault_q    (fault_q),
    .rec_start  (rec_start),
    .lp_mask    (lp_mask),
    .trip       (trip)
  );

  lsr_rec_timer #(.REC_TICKS(REC_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rec_start),
    .tick   (tick),
    .active (win_active)
  );

  assign gate_drive_en   = !dis && !fault_q;
  assign dac_en          = !dis && !fault_q;
  assign fault_out       = fault_q | win_active;
  assign lo_power_masked = lo_power_flag & ~lp_mask;

  p_enables_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> (!gate_drive_en && !dac_en && fault_out));
  p_mask_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> !lo_power_masked);
  p_recover_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_start && !trip) |=> (fault_out && (gate_drive_en == !dis)));
  p_follow_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_q |-> (gate_drive_en == !(tx_disable_pin || tx_disable_ctl)));
endmodule

// File: tb/test_laser_safety_sup.sv
module test_laser_safety_sup;
  localparam int TICKS = 5;

  logic clk = 0, rst_n = 0, tick = 0;
  logic pin = 0, ctl = 0, hb = 0, hp = 0, lp = 0;
  logic gate_en, dac_en, fault_out, lp_m;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R10";
  bit done = 0;

  always #2 clk = ~clk;

  laser_safety_sup #(.REC_TICKS(TICKS)) i_laser_safety_sup (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .tx_disable_pin(pin), .tx_disable_ctl(ctl),
    .hi_bias_flag(hb), .hi_power_flag(hp), .lo_power_flag(lp),
    .gate_drive_en(gate_en), .dac_en(dac_en),
    .fault_out(fault_out), .lo_power_masked(lp_m));

  // tick every third clock, changed after the edge
  always @(posedge clk) begin
    cyc++;
    #1 tick = (cyc % 3 == 0);
  end

  // behavioural reference
  int m_fault = 0, m_cnt = 0, m_disq = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fault = 0; m_cnt = 0; m_disq = 0;
    end else begin
      int d, st, msk, tr;
      d   = (pin || ctl);
      st  = (m_disq && !d && (m_fault || m_cnt > 0));
      msk = (m_cnt > 0) || st;
      tr  = !d && (hb || hp || (lp && !msk));
      if (tr) m_fault = 1; else if (st) m_fault = 0;
      if (st) m_cnt = TICKS; else if (tick && m_cnt > 0) m_cnt--;
      m_disq = d;
    end
  end

  task automatic check(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", t, what, act, exp, cyc);
    end
  endtask

  // compare every cycle, away from the edge
  always @(negedge clk) if (rst_n && !done) begin
    int d, st, e_en, e_f, e_lp;
    d    = (pin || ctl);
    st   = (m_disq && !d && (m_fault || m_cnt > 0));
    e_en = (!d && !m_fault);
    e_f  = (m_fault || m_cnt > 0);
    e_lp = (lp && !(m_cnt > 0 || st));
    check(tag, "gate_drive_en", gate_en, e_en);
    check(tag, "dac_en", dac_en, e_en);
    check(tag, "fault_out", fault_out, e_f);
    check(tag, "lo_power_masked", lp_m, e_lp);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R10: reset state
    tag = "R10";
    check("R10", "fault_out after reset", fault_out, 0);
    check("R10", "gate_drive_en after reset", gate_en, 1);
    step(2);

    // R1: OR of pin and bit
    tag = "R1";
    pin = 1; step(2); check("R1", "gate with pin", gate_en, 0);
    pin = 0; ctl = 1; step(2); check("R1", "dac with ctl", dac_en, 0);
    pin = 1; step(2); pin = 0; step(1); ctl = 0; step(2);

    // R2: shutdown with every flag high
    tag = "R2";
    ctl = 1; hb = 1; hp = 1; lp = 1; step(4);
    check("R2", "fault_out in shutdown", fault_out, 0);
    hb = 0; hp = 0; lp = 0; step(1);
    // R11: release without fault opens no window
    tag = "R11";
    ctl = 0; lp = 1;
    #0 check("R11", "lo_power_masked on idle release", lp_m, 1);
    lp = 0; step(2);
    check("R11", "fault_out after idle release", fault_out, 0);

    // R3 / R5: high-bias trip held
    tag = "R3";
    hb = 1; step(1); hb = 0;
    check("R3", "fault_out after bias trip", fault_out, 1);
    check("R3", "gate after bias trip", gate_en, 0);
    tag = "R5"; step(7);
    check("R5", "fault held", fault_out, 1);

    // R6: recovery and window length
    tag = "R6";
    pin = 1; step(2); pin = 0; step(1);
    check("R6", "gate after recovery", gate_en, 1);
    check("R6", "fault_out in window", fault_out, 1);
    begin
      int seen = 0;
      for (int i = 0; i < 40 && fault_out; i++) begin
        @(posedge clk); if (tick) seen++; #1;
      end
      check("R6", "ticks until fault_out low", seen, TICKS);
    end

    // R4: low power outside window trips
    tag = "R4";
    lp = 1; step(1); lp = 0;
    check("R4", "fault_out after low power", fault_out, 1);

    // R7: low power masked inside window
    tag = "R7";
    ctl = 1; step(2); ctl = 0; lp = 1; step(1);
    check("R7", "lo_power_masked in window", lp_m, 0);
    step(3);
    check("R7", "no trip from low power", gate_en, 1);
    lp = 0; step(20);

    // R8: high power during window
    tag = "R8";
    hp = 1; step(1); hp = 0; step(1);
    pin = 1; step(1); pin = 0; step(2);
    hp = 1; step(1); hp = 0;
    check("R8", "fault after hi power in window", fault_out, 1);
    check("R8", "gate after hi power in window", gate_en, 0);
    pin = 1; step(1); pin = 0; step(20);

    // R9: restart of the window
    tag = "R9";
    hb = 1; step(1); hb = 0;
    pin = 1; step(1); pin = 0; step(6);
    pin = 1; step(1); pin = 0; step(1);
    begin
      int seen = 0;
      for (int i = 0; i < 40 && fault_out; i++) begin
        @(posedge clk); if (tick) seen++; #1;
      end
      check("R9", "ticks after restart", seen, TICKS);
    end
    step(4);
    finish_run();
  end
endmodule